// File: doc/BRIEF.md
# Auxiliary Counter Identification Register with Read-Permission Arbiter

This block holds the read-only 64-bit identification word for a group of up to sixteen auxiliary activity counters. The low half of the word shows which counters exist. The next sixteen bits show which of those counters also carry a virtual offset register. Both presence masks are parameters fixed at elaboration, and the top 32 bits are always zero.

Every read request carries the requester's privilege level (0 to 3), a user-level enable, trap controls for levels 2 and 3, and platform flags: whether the counter group exists, whether levels 2 and 3 are present or enabled, a flag that routes user faults to level 2, and two flags that choose an undefined result over a level-3 trap. A fixed priority chain turns these into exactly one outcome. The outcome is the identification word, an undefined-instruction fault, or a trap to a named level with syndrome class 0x18. The outcome is registered and appears one clock after the request pulse.

Top module: `aux_ctr_id_gate`

## Requirements
- R1: A permitted read returns bits [15:0] equal to the counter mask, bits [31:16] equal to the offset mask, and bits [63:32] zero. An offset bit may be set only where the counter bit is set, and elaboration stops otherwise. With the default masks the word is 0x000000002161A5F3.
- R2: When `grp_present` is 0, a request at any level gives undefined.
- R3: At level 0 the checks run in this order. First, with level 3 present, `undef_first` set and the level-3 trap control set, the result is undefined. Second, a clear user enable traps, to level 2 if level 2 is enabled and `lvl2_route` is set, and to level 1 otherwise. Third, level 2 enabled with its trap control set traps to level 2. Fourth, level 3 present with its trap control set gives undefined if `undef_sel` is 1 and a trap to level 3 if it is 0. Last, the read is permitted.
- R4: At level 1 the chain of R3 applies without the user-enable step, so the user enable has no effect.
- R5: At level 2 only the level-3 steps of R3 apply, and the user enable and level-2 controls have no effect.
- R6: At level 3, with the group present, the read is always permitted.
- R7: A trap reports `rsp_class` = 0x18 and `rsp_target` = the target level (1, 2 or 3). Any other outcome reports 0 on both.
- R8: Each request gives exactly one of `rsp_read`, `rsp_undef` and `rsp_trap`, in the cycle after `req_valid` was high. `rsp_data` is nonzero only together with `rsp_read`.
- R9: In a cycle after a clock with no request, and during reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle read request |
| req_level | input | 2 | Privilege level of the requester |
| grp_present | input | 1 | Counter group exists |
| user_en | input | 1 | User-level access enable |
| lvl2_on | input | 1 | Level 2 is enabled |
| lvl2_route | input | 1 | Route user-level faults to level 2 |
| lvl2_trap | input | 1 | Level-2 trap control |
| lvl3_on | input | 1 | Level 3 exists |
| lvl3_trap | input | 1 | Level-3 trap control |
| undef_first | input | 1 | Level-3 undefined takes top priority |
| undef_sel | input | 1 | Level-3 trap becomes undefined |
| rsp_read | output | 1 | Read permitted |
| rsp_undef | output | 1 | Undefined-instruction fault |
| rsp_trap | output | 1 | Trap taken |
| rsp_target | output | 2 | Trap target level |
| rsp_class | output | 6 | Trap syndrome class |
| rsp_data | output | 64 | Identification word on a permitted read |

## Verification
Every outcome, the data word and the syndrome fields are due exactly one clock after the edge that samples `req_valid`. The bench drives a request at a falling edge and samples the response at the next falling edge, halfway between the capturing edge and the edge that replaces the response. An extra falling-edge sample after a request-free clock confirms that the outputs return to zero. The reset check lowers `rst_n` while a response is showing and samples a nanosecond later, because the clear does not wait for a clock.

// File: rtl/actr_pkg.sv
package actr_pkg;

  localparam int ID_W     = 64;
  localparam int MAX_CTR  = 16;
  localparam int CLASS_W  = 6;
  localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h18;

  typedef enum logic [1:0] {LVL0 = 2'd0, LVL1 = 2'd1, LVL2 = 2'd2, LVL3 = 2'd3} lvl_e;

  typedef struct packed {
    logic grp_present;
    logic user_en;
    logic lvl2_on;
    logic lvl2_route;
    logic lvl2_trap;
    logic lvl3_on;
    logic lvl3_trap;
    logic undef_first;
    logic undef_sel;
  } ctl_t;

  // one-hot {read, undef, trap}
  typedef enum logic [2:0] {
    OUT_NONE  = 3'b000,
    OUT_READ  = 3'b100,
    OUT_UNDEF = 3'b010,
    OUT_TRAP  = 3'b001
  } out_e;

  typedef struct packed {
    out_e       kind;
    logic [1:0] tgt;
  } verdict_t;

  // Priority chain deciding a read request outcome.
  function automatic verdict_t judge(input lvl_e lvl, input ctl_t c);
    verdict_t v;
    logic     l3_gate;
    l3_gate = c.lvl3_on && c.lvl3_trap;
    v.kind  = OUT_READ;
    v.tgt   = 2'd0;
    if (!c.grp_present) begin
      v.kind = OUT_UNDEF;
    end else if (lvl == LVL3) begin
      v.kind = OUT_READ;
    end else if (l3_gate && c.undef_first) begin
      v.kind = OUT_UNDEF;
    end else if (lvl == LVL0 && !c.user_en) begin
      v.kind = OUT_TRAP;
      v.tgt  = (c.lvl2_on && c.lvl2_route) ? 2'd2 : 2'd1;
    end else if (lvl != LVL2 && c.lvl2_on && c.lvl2_trap) begin
      v.kind = OUT_TRAP;
      v.tgt  = 2'd2;
    end else if (l3_gate) begin
      v.kind = c.undef_sel ? OUT_UNDEF : OUT_TRAP;
      v.tgt  = c.undef_sel ? 2'd0 : 2'd3;
    end
    return v;
  endfunction

  function automatic logic masks_consistent(input logic [MAX_CTR-1:0] ctr,
                                            input logic [MAX_CTR-1:0] off);
    return (off & ~ctr) == '0;
  endfunction

endpackage

// File: rtl/actr_id_rom.sv
module actr_id_rom
  import actr_pkg::*;
#(
  parameter int                  NUM_CTR  = 16,
  parameter logic [NUM_CTR-1:0]  CTR_MASK = 16'hA5F3,
  parameter logic [NUM_CTR-1:0]  OFF_MASK = 16'h2161
) (
  output logic [ID_W-1:0] id_word
);
  localparam int OFF_BASE = MAX_CTR;
  localparam logic [MAX_CTR-1:0] CTR_X = MAX_CTR'(CTR_MASK);
  localparam logic [MAX_CTR-1:0] OFF_X = MAX_CTR'(OFF_MASK);

  if (NUM_CTR > MAX_CTR || NUM_CTR < 1) begin : g_bad_count
    $error("counter count out of range");
  end
  if (!masks_consistent(CTR_X, OFF_X)) begin : g_bad_mask
    $error("offset mask names a counter that is absent");
  end

  for (genvar b = 0; b < ID_W; b++) begin : g_bit
    if (b < MAX_CTR) begin : g_ctr
      assign id_word[b] = CTR_X[b];
    end else if (b < 2 * MAX_CTR) begin : g_off
      assign id_word[b] = CTR_X[b-OFF_BASE] & OFF_X[b-OFF_BASE];
    end else begin : g_zero
      assign id_word[b] = 1'b0;
    end
  end
endmodule

// File: rtl/actr_access_arb.sv
module actr_access_arb
  import actr_pkg::*;
(
  input  logic [1:0] level,
  input  ctl_t       ctl,
  output verdict_t   verdict
);
  always_comb verdict = judge(lvl_e'(level), ctl);
endmodule

// File: rtl/aux_ctr_id_gate.sv
module aux_ctr_id_gate
  import actr_pkg::*;
#(
  parameter int                  NUM_CTR  = 16,
  parameter logic [NUM_CTR-1:0]  CTR_MASK = 16'hA5F3,
  parameter logic [NUM_CTR-1:0]  OFF_MASK = 16'h2161
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_level,
  input  logic          grp_present,
  input  logic          user_en,
  input  logic          lvl2_on,
  input  logic          lvl2_route,
  input  logic          lvl2_trap,
  input  logic          lvl3_on,
  input  logic          lvl3_trap,
  input  logic          undef_first,
  input  logic          undef_sel,
  output logic          rsp_read,
  output logic          rsp_undef,
  output logic          rsp_trap,
  output logic [1:0]    rsp_target,
  output logic [5:0]    rsp_class,
  output logic [63:0]   rsp_data
);
  ctl_t            ctl;
  verdict_t        arb_verdict;
  logic [ID_W-1:0] id_word;
  out_e            kind_q;
  logic [1:0]      tgt_q;
  logic [ID_W-1:0] data_q;

  assign ctl = '{grp_present: grp_present, user_en: user_en, lvl2_on: lvl2_on,
                 lvl2_route: lvl2_route, lvl2_trap: lvl2_trap, lvl3_on: lvl3_on,
                 lvl3_trap: lvl3_trap, undef_first: undef_first, undef_sel: undef_sel};

  actr_id_rom #(.NUM_CTR(NUM_CTR), .CTR_MASK(CTR_MASK), .OFF_MASK(OFF_MASK))
    u_rom (.id_word(id_word));

  actr_access_arb u_arb (.level(req_level), .ctl(ctl), .verdict(arb_verdict));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= OUT_NONE;
      tgt_q  <= '0;
      data_q <= '0;
    end else if (req_valid) begin
      kind_q <= arb_verdict.kind;
      tgt_q  <= arb_verdict.tgt;
      data_q <= (arb_verdict.kind == OUT_READ) ? id_word : '0;
    end else begin
      kind_q <= OUT_NONE;
      tgt_q  <= '0;
      data_q <= '0;
    end
  end

  assign rsp_read   = kind_q[2];
  assign rsp_undef  = kind_q[1];
  assign rsp_trap   = kind_q[0];
  assign rsp_target = tgt_q;
  assign rsp_class  = kind_q[0] ? TRAP_CLASS : '0;
  assign rsp_data   = data_q;
endmodule

// File: rtl/actr_id_chk.sv
module actr_id_chk #(
  parameter int                 NUM_CTR  = 16,
  parameter logic [NUM_CTR-1:0] CTR_MASK = 16'hA5F3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_level,
  input logic        grp_present,
  input logic        lvl3_on,
  input logic        rsp_read,
  input logic        rsp_undef,
  input logic        rsp_trap,
  input logic [1:0]  rsp_target,
  input logic [5:0]  rsp_class,
  input logic [63:0] rsp_data
);
  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $countones({rsp_read, rsp_undef, rsp_trap}) == 1);

  // R8
  data_with_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_read |-> rsp_data == 64'd0);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_read && !rsp_undef && !rsp_trap && rsp_target == 2'd0));

  // R2
  absent_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !grp_present) |=> rsp_undef);

  // R6
  top_level_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && grp_present && req_level == 2'd3) |=> rsp_read);

  // R5
  lvl2_no_lvl3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && grp_present && req_level == 2'd2 && !lvl3_on) |=> rsp_read);

  // R7
  trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> (rsp_class == 6'h18 && rsp_target != 2'd0));

  // R7
  notrap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_trap |-> (rsp_class == 6'h0 && rsp_target == 2'd0));

  // R1
  data_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_read |-> (rsp_data[63:32] == 32'd0 && rsp_data[NUM_CTR-1:0] == CTR_MASK
                  && (rsp_data[31:16] & ~rsp_data[15:0]) == 16'd0));
endmodule

bind aux_ctr_id_gate actr_id_chk #(.NUM_CTR(NUM_CTR), .CTR_MASK(CTR_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
  .grp_present(grp_present), .lvl3_on(lvl3_on), .rsp_read(rsp_read),
  .rsp_undef(rsp_undef), .rsp_trap(rsp_trap), .rsp_target(rsp_target),
  .rsp_class(rsp_class), .rsp_data(rsp_data));

// File: tb/aux_ctr_id_gate_bench.sv
module aux_ctr_id_gate_bench;
  localparam logic [63:0] EXP_ID = 64'h0000_0000_2161_A5F3;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [1:0] req_level = 2'd0;
  logic grp_present = 0, user_en = 0, lvl2_on = 0, lvl2_route = 0, lvl2_trap = 0;
  logic lvl3_on = 0, lvl3_trap = 0, undef_first = 0, undef_sel = 0;
  logic rsp_read, rsp_undef, rsp_trap;
  logic [1:0] rsp_target;
  logic [5:0] rsp_class;
  logic [63:0] rsp_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  aux_ctr_id_gate u_aux_ctr_id_gate (.*);

  // {level[1:0], feat uen l2en route l2trap l3on l3trap ufirst usel, kind{read,undef,trap}, tgt}
  localparam logic [15:0] VECS [16] = '{
    16'b00_110000000_100_00, // R3 all clear, read
    16'b00_101100000_001_10, // R3 user enable clear, routed to 2
    16'b00_100100000_001_01, // R3 user enable clear, level 2 off -> 1
    16'b00_100001110_010_00, // R3 early undefined beats user enable
    16'b00_111011100_001_10, // R3 level-2 trap beats level-3 trap
    16'b00_110001101_010_00, // R3 level-3 trap as undefined
    16'b00_110001100_001_11, // R3 level-3 trap
    16'b01_100000000_100_00, // R4 user enable ignored
    16'b01_101010000_001_10, // R4 level-2 trap
    16'b01_110010000_100_00, // R4 level-2 control with level 2 off
    16'b10_101010000_100_00, // R5 level-2 controls ignored
    16'b10_110001100_001_11, // R5 level-3 trap
    16'b10_110000110_100_00, // R5 level 3 absent
    16'b11_100001110_100_00, // R6 always read
    16'b11_000000000_010_00, // R2 group absent at level 3
    16'b01_111011110_010_00  // R4 early undefined first
  };

  function automatic logic [4:0] ref_out(input logic [1:0] lv, input logic [8:0] f);
    logic feat, uen, l2en, route, l2t, l3p, l3t, ufirst, usel, gate3;
    {feat, uen, l2en, route, l2t, l3p, l3t, ufirst, usel} = f;
    gate3 = l3p & l3t;
    if (!feat) return 5'b010_00;
    case (lv)
      2'd3: return 5'b100_00;
      default: begin
        if (gate3 && ufirst) return 5'b010_00;
        if (lv == 2'd0 && !uen) return (l2en && route) ? 5'b001_10 : 5'b001_01;
        if (lv != 2'd2 && l2en && l2t) return 5'b001_10;
        if (gate3) return usel ? 5'b010_00 : 5'b001_11;
        return 5'b100_00;
      end
    endcase
  endfunction

  task automatic drive(input logic [1:0] lv, input logic [8:0] f);
    @(negedge clk);
    req_level = lv;
    {grp_present, user_en, lvl2_on, lvl2_route, lvl2_trap, lvl3_on, lvl3_trap,
     undef_first, undef_sel} = f;
    req_valid = 1'b1;
  endtask

  task automatic check_rsp(input string rq, input logic [4:0] exp);
    logic [63:0] ed;
    logic [5:0]  ec;
    ed = exp[4] ? EXP_ID : 64'd0;
    ec = exp[2] ? 6'h18 : 6'h0;
    checks++;
    if ({rsp_read, rsp_undef, rsp_trap, rsp_target} !== exp || rsp_data !== ed
        || rsp_class !== ec) begin
      fails++;
      $display("FAIL %s: got out=%b tgt=%0d cls=%h data=%h, expected out=%b tgt=%0d cls=%h data=%h",
               rq, {rsp_read, rsp_undef, rsp_trap}, rsp_target, rsp_class, rsp_data,
               exp[4:2], exp[1:0], ec, ed);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    #3 check_rsp("R9 reset", 5'b000_00);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      drive(VECS[i][15:14], VECS[i][13:5]);
      @(negedge clk);
      req_valid = 1'b0;
      check_rsp($sformatf("R%0s vec %0d",
                i == 14 ? "2" : (VECS[i][15:14] == 2'd0 ? "3" : VECS[i][15:14] == 2'd1 ? "4" :
                VECS[i][15:14] == 2'd2 ? "5" : "6"), i), VECS[i][4:0]);
      @(negedge clk);
      check_rsp("R9 idle after request", 5'b000_00);
    end

    // R1 word layout on a permitted read, back-to-back sweep of every combination
    for (int n = 0; n < 2048; n++) begin
      drive(n[10:9], n[8:0]);
      @(negedge clk);
      check_rsp(!n[8] ? "R2 sweep" : n[10:9] == 2'd0 ? "R3 sweep" : n[10:9] == 2'd1 ? "R4 sweep" :
                n[10:9] == 2'd2 ? "R5 sweep" : "R6 sweep", ref_out(n[10:9], n[8:0]));
      if (rsp_read) begin
        checks++;
        if (rsp_data[63:32] !== 32'd0 || (rsp_data[31:16] & ~rsp_data[15:0]) !== 16'd0) begin
          fails++;
          $display("FAIL R1: got %h, expected %h", rsp_data, EXP_ID);
        end
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    check_rsp("R8 single pulse, R9 idle", 5'b000_00);

    // R7 trap fields, R9 asynchronous clear of a live response
    drive(2'd2, 9'b110001100);
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("R7 level-3 trap", 5'b001_11);
    drive(2'd3, 9'b100000000);
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("R1 read before reset", 5'b100_00);
    rst_n = 1'b0;
    #1 check_rsp("R9 reset clears", 5'b000_00);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check_rsp("R9 after reset", 5'b000_00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule